// File: doc/BRIEF.md
# Asynchronous Byte Write Port with Ready/Busy Status

This block lets an external processor-style master, which has no shared clock, push bytes one at a time into a configuration data buffer. Two select pins of opposite polarity gate access. An active-low write strobe delivers a byte, and an active-low read strobe asks for status. All select and strobe pins pass through a two-stage synchroniser into the system clock domain. The block acts on the synchronised falling edge of the write strobe, so one strobe pulse yields exactly one byte, however long the pulse lasts.

A captured byte is offered downstream on a valid/ready stream interface. `m_valid` rises when the byte is captured. `m_data` then stays stable until a cycle in which `m_ready` is high, and that cycle completes the transfer. The consumer may hold `m_ready` low for any number of cycles; that is the only back-pressure. While a byte is held, the port is busy. A status read drives the most significant data bit high for ready and low for busy, and drives no other bit. A write that arrives while the port is busy is discarded and sets a sticky overrun flag. When both strobes are low together, the write is acted on and the status read is withheld.

Top module: `async_byte_port`

## Requirements
- R1: The port is selected only when `sel_a_n` is 0 and `sel_b` is 1. In the other three combinations, strobes change neither `m_valid` nor `m_data`, and `pad_oe` stays 8'h00.
- R2: While the port is selected and idle (`m_valid`=0), a falling write strobe captures `pad_din` into `m_data` and raises `m_valid`. A strobe held low captures only once.
- R3: `m_valid` and `m_data` hold until a clock edge where `m_valid` and `m_ready` are both 1. On the cycle after that edge, `m_valid` is 0.
- R4: While the port is selected and the read strobe is low, `pad_oe` is 8'h80 (only bit 7 driven). `pad_dout[7]` is 1 when no byte is held and 0 while a byte is held.
- R5: With both strobes low, the write is captured and `pad_oe` stays 8'h00.
- R6: A write falling edge while a byte is held leaves `m_data` unchanged and sets `overrun`. `overrun` stays 1 until reset.
- R7: After the read strobe rises, `pad_oe` stays at 8'h80 for two further clock edges (the synchroniser stages) and returns to 8'h00 on the third.
- R8: After reset, `m_valid`=0, `overrun`=0 and `pad_oe`=8'h00.
- R9: A write strobe falling just after a clock edge produces `m_valid`=1 on the third rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| wstb_n | input | 1 | Write strobe, active low |
| rstb_n | input | 1 | Status read strobe, active low |
| pad_din | input | 8 | Data bus, input side |
| pad_dout | output | 8 | Data bus, output side (bit 7 carries status) |
| pad_oe | output | 8 | Per-bit output enable for the data bus |
| m_valid | output | 1 | Byte available downstream |
| m_ready | input | 1 | Downstream accepts the byte |
| m_data | output | 8 | Captured byte |
| overrun | output | 1 | Sticky flag: a write was dropped while busy |

## Verification
The assertions assume that `pad_din` is stable from before the write strobe falls until after the write strobe rises. They also assume that the select pins do not change while a strobe is low, since the data bus itself is not synchronised. The bench always sets the select pins and data some cycles before it lowers a strobe, and holds them until the strobe has been high for several cycles. Each strobe is also kept low for at least four clock periods, so every edge passes cleanly through the synchroniser.

// File: rtl/abp_pkg.sv
package abp_pkg;
  // Synchronised view of the control pins, already decoded to active-high meaning.
  typedef struct packed {
    logic sel;
    logic wr_low;
    logic rd_low;
  } strobe_t;

  // Raw pin order inside the synchroniser vector: {sel_a_n, sel_b, wstb_n, rstb_n}
  localparam int PIN_W = 4;
  localparam logic [PIN_W-1:0] PIN_IDLE = 4'b1011;

  function automatic strobe_t decode_pins(input logic [PIN_W-1:0] p);
    strobe_t s;
    s.sel    = ~p[3] & p[2];
    s.wr_low = ~p[1];
    s.rd_low = ~p[0];
    return s;
  endfunction
endpackage

// File: rtl/abp_sync.sv
module abp_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else     chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/abp_strobe_ctl.sv
module abp_strobe_ctl
  import abp_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  strobe_t s,
  output logic    wr_fall,
  output logic    rd_status
);
  logic wr_low_q;

  always_ff @(posedge clk) begin
    if (rst) wr_low_q <= 1'b0;
    else     wr_low_q <= s.wr_low;
  end

  // A write edge is seen once per pulse, and only while the port is selected.
  assign wr_fall   = s.sel & s.wr_low & ~wr_low_q;
  // The write strobe wins over the read strobe.
  assign rd_status = s.sel & s.rd_low & ~s.wr_low;

  a_r2_one_per_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_fall |=> !wr_fall);
endmodule

// File: rtl/abp_holdbuf.sv
module abp_holdbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          m_ready,
  output logic          m_valid,
  output logic [DW-1:0] m_data,
  output logic          overrun
);
  logic          full_q;
  logic [DW-1:0] byte_q;
  logic          ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      byte_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (full_q && m_ready) full_q <= 1'b0;
      if (load) begin
        if (!full_q) begin
          full_q <= 1'b1;
          byte_q <= din;
        end else begin
          ovr_q <= 1'b1;
        end
      end
    end
  end

  assign m_valid = full_q;
  assign m_data  = byte_q;
  assign overrun = ovr_q;

  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    (load && !m_valid) |=> (m_valid && m_data == $past(din)));
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  a_r3_release: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ready) |=> !m_valid);
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  a_r6_drop: assert property (@(posedge clk) disable iff (rst)
    (load && m_valid) |=> (overrun && m_data == $past(m_data)));
endmodule

// File: rtl/abp_status_drv.sv
module abp_status_drv #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_status,
  input  logic          ready_flag,
  output logic [DW-1:0] dout,
  output logic [DW-1:0] oe
);
  logic drive_q;

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= rd_status;
  end

  assign dout = {ready_flag, {(DW-1){1'b0}}};
  assign oe   = {drive_q, {(DW-1){1'b0}}};
endmodule

// File: rtl/async_byte_port.sv
module async_byte_port
  import abp_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          wstb_n,
  input  logic          rstb_n,
  input  logic [DW-1:0] pad_din,
  output logic [DW-1:0] pad_dout,
  output logic [DW-1:0] pad_oe,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  output logic          overrun
);
  logic [PIN_W-1:0] pins_s;
  strobe_t          strb;
  logic             wr_fall;
  logic             rd_status;

  abp_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst),
    .d({sel_a_n, sel_b, wstb_n, rstb_n}),
    .q(pins_s)
  );

  assign strb = decode_pins(pins_s);

  abp_strobe_ctl u_ctl (
    .clk(clk), .rst(rst), .s(strb),
    .wr_fall(wr_fall), .rd_status(rd_status)
  );

  abp_holdbuf #(.DW(DW)) u_buf (
    .clk(clk), .rst(rst), .load(wr_fall), .din(pad_din),
    .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data), .overrun(overrun)
  );

  abp_status_drv #(.DW(DW)) u_drv (
    .clk(clk), .rst(rst), .rd_status(rd_status), .ready_flag(~m_valid),
    .dout(pad_dout), .oe(pad_oe)
  );

  a_r4_status_value: assert property (@(posedge clk) disable iff (rst)
    pad_oe[DW-1] |-> (pad_dout[DW-1] == !m_valid));
  a_r5_write_priority: assert property (@(posedge clk) disable iff (rst)
    strb.wr_low |=> (pad_oe == '0));
  a_r1_deselect: assert property (@(posedge clk) disable iff (rst)
    !strb.sel |=> (pad_oe == '0));
endmodule

// File: tb/tb_async_byte_port.sv
`timescale 1ns/1ps
module tb_async_byte_port;
  logic       clk = 1'b0;
  logic       rst;
  logic       sel_a_n, sel_b, wstb_n, rstb_n, m_ready;
  logic [7:0] pad_din;
  logic [7:0] pad_dout, pad_oe, m_data;
  logic       m_valid, overrun;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  async_byte_port dut (
    .clk(clk), .rst(rst), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .wstb_n(wstb_n), .rstb_n(rstb_n), .pad_din(pad_din),
    .pad_dout(pad_dout), .pad_oe(pad_oe), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .overrun(overrun)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] b);
    pad_din = b;
    wait_n(2);
    wstb_n = 1'b0;
    wait_n(4);
    wstb_n = 1'b1;
    wait_n(4);
  endtask

  task automatic accept;
    m_ready = 1'b1;
    wait_n(1);
    m_ready = 1'b0;
  endtask

  task automatic set_sel(input logic a_n, input logic b);
    sel_a_n = a_n;
    sel_b   = b;
    wait_n(4);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; sel_a_n = 1'b1; sel_b = 1'b0; wstb_n = 1'b1; rstb_n = 1'b1;
    m_ready = 1'b0; pad_din = 8'h00;
    wait_n(4);
    rst = 1'b0;
    wait_n(1);
    // R8: reset state
    check("R8 m_valid", m_valid, 0);
    check("R8 overrun", overrun, 0);
    check("R8 pad_oe", pad_oe, 0);

    // R1: every non-selecting combination ignores both strobes
    for (int c = 0; c < 4; c++) begin
      if (c == 1) continue;   // c = {sel_a_n, sel_b}; 2'b01 selects
      set_sel(c[1], c[0]);
      write_byte(8'hA5);
      check("R1 write ignored", m_valid, 0);
      rstb_n = 1'b0;
      wait_n(5);
      check("R1 bus undriven", pad_oe, 0);
      rstb_n = 1'b1;
      wait_n(4);
    end

    set_sel(1'b0, 1'b1);
    // R4: ready status while empty
    rstb_n = 1'b0;
    wait_n(5);
    check("R4 oe ready", pad_oe, 8'h80);
    check("R4 status ready", pad_dout[7], 1);
    // R7: release timing
    rstb_n = 1'b1;
    wait_n(2);
    check("R7 oe held through sync", pad_oe, 8'h80);
    wait_n(1);
    check("R7 oe released", pad_oe, 0);
    wait_n(2);

    // R2/R3/R9: sweep every byte value
    for (int v = 0; v < 256; v++) begin
      pad_din = v[7:0];
      wait_n(2);
      wstb_n = 1'b0;
      wait_n(2);
      if (v < 4) check("R9 not before third edge", m_valid, 0);
      wait_n(1);
      if (v < 4) check("R9 valid on third edge", m_valid, 1);
      wait_n(3);                      // strobe held low: still one capture
      check("R2 captured byte", m_data, v);
      wstb_n = 1'b1;
      wait_n(3 + (v % 5));            // varied back-pressure
      check("R3 held under back-pressure", {m_valid, m_data}, {1'b1, v[7:0]});
      accept();
      check("R3 released after handshake", m_valid, 0);
      check("R2 no second capture", overrun, 0);
    end

    // R4: busy status while a byte is held
    write_byte(8'h3C);
    rstb_n = 1'b0;
    wait_n(5);
    check("R4 oe busy", pad_oe, 8'h80);
    check("R4 status busy", pad_dout[7], 0);
    rstb_n = 1'b1;
    wait_n(4);

    // R6: write while busy is dropped, flag sticks
    write_byte(8'hC3);
    check("R6 byte kept", m_data, 8'h3C);
    check("R6 overrun set", overrun, 1);
    accept();
    wait_n(3);
    check("R6 overrun sticky", overrun, 1);
    rst = 1'b1;
    wait_n(1);
    rst = 1'b0;
    wait_n(1);
    check("R8 overrun cleared by reset", overrun, 0);
    check("R8 valid cleared by reset", m_valid, 0);

    // R5: both strobes low together
    wait_n(3);
    pad_din = 8'h5A;
    wait_n(2);
    wstb_n = 1'b0;
    rstb_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      wait_n(1);
      check("R5 no status drive", pad_oe, 0);
    end
    check("R5 write taken", {m_valid, m_data}, {1'b1, 8'h5A});
    wstb_n = 1'b1;
    rstb_n = 1'b1;
    wait_n(4);
    accept();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule